// File: doc/BRIEF.md
# Capture Timer with Direction Control

This block is a free-running counter/timer that advances on a qualified count tick. While it runs, a falling edge on an external, asynchronous capture pin can copy the live count into a holding register. The count can go up or down. A wrap past either end of the range raises one shared wrap flag. A capture raises a separate capture flag. Software clears each flag with its own strobe, and an enable gates the two flags onto a single registered interrupt request.

Software can preload the count through a write strobe. The count tick comes from elsewhere, for example a prescaled clock or an already synchronized counter-pin event. The capture pin is synchronized inside the block.

Top module: `capt_tmr`

## Requirements
- R1: The count advances by exactly one on a clock edge only when `capMode`, `runEn` and `tick` are all 1 and `cntWrEn` is 0. Otherwise it holds.
- R2: With `countDown` = 0, an advance from all-ones to zero sets `wrapFlag`.
- R3: With `countDown` = 1, each advance subtracts one. An advance from zero to all-ones sets `wrapFlag`.
- R4: With `capArm` = 1 and `capMode` = 1, a high-to-low transition on `capPin` copies `count` into `capValue` and sets `capFlag`. Both happen on the third rising clock edge, counting the first edge that samples the pin low as edge one. The timer does not need to be running.
- R5: With `capArm` = 0, falling edges on `capPin` leave `capValue` and `capFlag` unchanged. Rising edges never capture, whatever the value of `capArm`.
- R6: When a capture and a count advance fall on the same edge, `capValue` receives the count from before that advance.
- R7: Each flag stays set until its clear strobe (`wrapClr` or `capClr`) is 1 at an edge. If a new event arrives on the same edge as the clear, the flag stays set.
- R8: `irq` is a register. After each edge it equals the `irqEn` value at that edge, ANDed with the OR of the two flags as updated on that edge.
- R9: Synchronous reset clears `count`, `capValue`, both flags and `irq`.
- R10: `cntWrEn` loads `cntWrData` into the count at the next edge, whether or not the timer runs. The load replaces any count advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable pulse |
| capPin | input | 1 | Asynchronous external capture input |
| runEn | input | 1 | Run control |
| capMode | input | 1 | Capture mode select; counting and capture need it at 1 |
| capArm | input | 1 | Capture enable |
| countDown | input | 1 | 1 selects down-counting |
| irqEn | input | 1 | Interrupt enable |
| cntWrEn | input | 1 | Count load strobe |
| cntWrData | input | WIDTH | Count load value |
| wrapClr | input | 1 | Wrap flag clear strobe |
| capClr | input | 1 | Capture flag clear strobe |
| count | output | WIDTH | Live count |
| capValue | output | WIDTH | Captured count |
| wrapFlag | output | 1 | Sticky overflow/underflow flag |
| capFlag | output | 1 | Sticky capture flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The count is swept over the eight values at each end of the range, in both directions, with a tick on every other cycle. This separates correct gating and stepping from an off-by-one or a missed wrap, and compares the wrap flag against plain arithmetic on the start value. Captures are tried with the timer stopped at several load values, and with the timer running up and down. The running case separates a pre-advance capture from a post-advance one, and the stopped case pins the three-edge latency. Pin edges with the capture enable off, rising pin edges, clears that coincide with events, and a load issued while the timer runs each probe one priority or masking rule.

// File: rtl/capt_tmr_pkg.sv
package capt_tmr_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic loadEn;     // take the software load value
    logic countEvt;   // advance the count by one
    logic countDown;  // direction of the advance
    logic capStrobe;  // copy the count into the capture register
  } tmrStrobe_t;
endpackage

// File: rtl/capt_tmr_ctrl.sv
module capt_tmr_ctrl
  import capt_tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       capPin,
  input  logic       runEn,
  input  logic       capMode,
  input  logic       capArm,
  input  logic       countDown,
  input  logic       irqEn,
  input  logic       cntWrEn,
  input  logic       wrapClr,
  input  logic       capClr,
  input  logic       wrapEvt,
  output tmrStrobe_t strobe,
  output logic       wrapFlag,
  output logic       capFlag,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          pinFall;
  logic          active;
  logic          wrapNext;
  logic          capNext;

  // Synchronizer chain; idle level of the pin is high
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ[0] <= capPin;
      prevQ    <= syncQ[LAST];
    end
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncQ[s] <= 1'b1;
        else     syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign pinFall = prevQ & ~syncQ[LAST];
  assign active  = capMode & runEn;

  always_comb begin
    strobe.loadEn    = cntWrEn;
    strobe.countEvt  = active & tick & ~cntWrEn;
    strobe.countDown = countDown;
    strobe.capStrobe = pinFall & capArm & capMode;
  end

  // An event in the same cycle as a clear keeps the flag set
  assign wrapNext = wrapEvt | (wrapFlag & ~wrapClr);
  assign capNext  = strobe.capStrobe | (capFlag & ~capClr);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrapFlag <= 1'b0;
      capFlag  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      wrapFlag <= wrapNext;
      capFlag  <= capNext;
      irq      <= irqEn & (wrapNext | capNext);
    end
  end
endmodule

// File: rtl/capt_tmr_dpath.sv
module capt_tmr_dpath
  import capt_tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrobe_t       strobe,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capValue,
  output logic             wrapEvt
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic atEnd;

  assign atEnd   = strobe.countDown ? (count == '0) : (count == TOP);
  assign wrapEvt = strobe.countEvt & atEnd;

  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (strobe.loadEn)   count <= loadData;
    else if (strobe.countEvt) count <= strobe.countDown ? count - ONE : count + ONE;
  end

  // Samples the count before this cycle's advance
  always_ff @(posedge clk) begin
    if (rst)                   capValue <= '0;
    else if (strobe.capStrobe) capValue <= count;
  end
endmodule

// File: rtl/capt_tmr.sv
module capt_tmr
  import capt_tmr_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             capPin,
  input  logic             runEn,
  input  logic             capMode,
  input  logic             capArm,
  input  logic             countDown,
  input  logic             irqEn,
  input  logic             cntWrEn,
  input  logic [WIDTH-1:0] cntWrData,
  input  logic             wrapClr,
  input  logic             capClr,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capValue,
  output logic             wrapFlag,
  output logic             capFlag,
  output logic             irq
);
  tmrStrobe_t strobe;
  logic       wrapEvt;

  capt_tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick), .capPin(capPin), .runEn(runEn),
    .capMode(capMode), .capArm(capArm), .countDown(countDown), .irqEn(irqEn),
    .cntWrEn(cntWrEn), .wrapClr(wrapClr), .capClr(capClr), .wrapEvt(wrapEvt),
    .strobe(strobe), .wrapFlag(wrapFlag), .capFlag(capFlag), .irq(irq)
  );

  capt_tmr_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .loadData(cntWrData),
    .count(count), .capValue(capValue), .wrapEvt(wrapEvt)
  );
endmodule

// File: rtl/capt_tmr_chk.sv
module capt_tmr_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             runEn,
  input logic             capMode,
  input logic             capArm,
  input logic             countDown,
  input logic             irqEn,
  input logic             cntWrEn,
  input logic [WIDTH-1:0] cntWrData,
  input logic             wrapClr,
  input logic             capClr,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] capValue,
  input logic             wrapFlag,
  input logic             capFlag,
  input logic             irq
);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!(capMode && runEn && tick) && !cntWrEn) |=> $stable(count));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cntWrEn |=> (count == $past(cntWrData)));

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (capMode && runEn && tick && !cntWrEn && !countDown && count == {WIDTH{1'b1}})
      |=> (count == '0 && wrapFlag));

  // R3
  down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (capMode && runEn && tick && !cntWrEn && countDown && count == '0)
      |=> (count == {WIDTH{1'b1}} && wrapFlag));

  // R5
  no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !capArm |=> $stable(capValue));

  // R7
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wrapFlag && !wrapClr) |=> wrapFlag);

  // R7
  cap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (capFlag && !capClr) |=> capFlag);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(irqEn) && (wrapFlag || capFlag))));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && capValue == '0 && !wrapFlag && !capFlag && !irq));
endmodule

bind capt_tmr capt_tmr_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .runEn(runEn), .capMode(capMode),
  .capArm(capArm), .countDown(countDown), .irqEn(irqEn), .cntWrEn(cntWrEn),
  .cntWrData(cntWrData), .wrapClr(wrapClr), .capClr(capClr), .count(count),
  .capValue(capValue), .wrapFlag(wrapFlag), .capFlag(capFlag), .irq(irq)
);

// File: tb/capt_tmr_test.sv
module capt_tmr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, tick, capPin, runEn, capMode, capArm, countDown, irqEn;
  logic        cntWrEn, wrapClr, capClr;
  logic [15:0] cntWrData;
  logic [15:0] count, capValue;
  logic        wrapFlag, capFlag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capt_tmr uut (
    .clk(clk), .rst(rst), .tick(tick), .capPin(capPin), .runEn(runEn),
    .capMode(capMode), .capArm(capArm), .countDown(countDown), .irqEn(irqEn),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .wrapClr(wrapClr), .capClr(capClr),
    .count(count), .capValue(capValue), .wrapFlag(wrapFlag), .capFlag(capFlag),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Loads a value with the timer stopped and clears both flags
  task automatic loadCnt(input logic [15:0] v);
    runEn = 1'b0; tick = 1'b0;
    cntWrEn = 1'b1; cntWrData = v; wrapClr = 1'b1; capClr = 1'b1;
    step(1);
    cntWrEn = 1'b0; wrapClr = 1'b0; capClr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; capPin = 1'b1; runEn = 1'b0; capMode = 1'b0;
    capArm = 1'b0; countDown = 1'b0; irqEn = 1'b0; cntWrEn = 1'b0;
    wrapClr = 1'b0; capClr = 1'b0; cntWrData = '0;
    step(3);
    // R9 reset state
    chk("R9 count", count, 0);
    chk("R9 capValue", capValue, 0);
    chk("R9 flags/irq", {wrapFlag, capFlag, irq}, 0);
    rst = 1'b0;
    capMode = 1'b1; irqEn = 1'b1;

    // R1 R2 R3: sweep both ends of the range, both directions, 4 ticks in 7 cycles
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] v, expCnt;
        logic        expWrap;
        v = (k < 8) ? 16'(k) : 16'(16'hFFF8 + k - 8);
        loadCnt(v);
        countDown = d[0]; runEn = 1'b1;
        for (int i = 0; i < 7; i++) begin
          tick = (i % 2 == 0);
          step(1);
        end
        runEn = 1'b0; tick = 1'b0;
        expCnt  = d[0] ? v - 16'd4 : v + 16'd4;
        expWrap = d[0] ? (v < 16'd4) : (v > 16'hFFFB);
        chk(d[0] ? "R3 down count" : "R1 up count", count, expCnt);
        chk(d[0] ? "R3 underflow flag" : "R2 overflow flag", wrapFlag, expWrap);
        chk("R8 irq follows wrap", irq, expWrap);
      end
    end
    countDown = 1'b0;

    // R1 gating: stopped, then mode off
    loadCnt(16'h0ABC);
    tick = 1'b1; step(3);
    chk("R1 hold when stopped", count, 16'h0ABC);
    capMode = 1'b0; runEn = 1'b1; step(3);
    chk("R1 hold when mode off", count, 16'h0ABC);
    capMode = 1'b1; runEn = 1'b0; tick = 1'b0;

    // R7 set wins over clear, then clear alone
    loadCnt(16'hFFFF);
    runEn = 1'b1; tick = 1'b1; wrapClr = 1'b1; step(1);
    runEn = 1'b0; tick = 1'b0; wrapClr = 1'b0;
    chk("R7 wrap set beats clear", wrapFlag, 1);
    chk("R2 wrap to zero", count, 0);
    wrapClr = 1'b1; step(1); wrapClr = 1'b0;
    chk("R7 wrap cleared", wrapFlag, 0);
    chk("R8 irq drops", irq, 0);

    // R10 load while running beats the count event
    loadCnt(16'h1234);
    runEn = 1'b1; tick = 1'b1; step(2);
    chk("R1 running count", count, 16'h1236);
    cntWrEn = 1'b1; cntWrData = 16'h4000; step(1);
    cntWrEn = 1'b0; runEn = 1'b0; tick = 1'b0;
    chk("R10 load priority", count, 16'h4000);

    // R4 stopped captures at several values, with latency check
    capArm = 1'b1;
    for (int j = 0; j < 4; j++) begin
      logic [15:0] v;
      v = (j == 0) ? 16'h0000 : (j == 1) ? 16'h00FF : (j == 2) ? 16'h8001 : 16'hFFFF;
      loadCnt(v);
      capPin = 1'b0; step(2);
      chk("R4 no capture before third edge", capFlag, 0);
      step(1);
      chk("R4 captured value", capValue, v);
      chk("R4 capture flag", capFlag, 1);
      chk("R8 irq on capture", irq, 1);
      loadCnt(~v);
      capPin = 1'b1; step(3);
      chk("R5 rising edge no capture flag", capFlag, 0);
      chk("R5 rising edge no capture value", capValue, v);
    end

    // R5 capture disabled
    capArm = 1'b0;
    loadCnt(16'h5555);
    capPin = 1'b0; step(4);
    chk("R5 disabled no flag", capFlag, 0);
    chk("R5 disabled value held", capValue, 16'hFFFF);
    capPin = 1'b1; step(3);
    capArm = 1'b1;

    // R6 capture while running, both directions
    for (int d = 0; d < 2; d++) begin
      loadCnt(16'h1000);
      countDown = d[0]; runEn = 1'b1; tick = 1'b1; capPin = 1'b0;
      step(3);
      runEn = 1'b0; tick = 1'b0;
      chk("R6 pre-advance capture", capValue, d[0] ? 16'h0FFE : 16'h1002);
      chk("R6 count after capture", count, d[0] ? 16'h0FFD : 16'h1003);
      capPin = 1'b1; step(3);
    end
    countDown = 1'b0;

    // R7 capture beats same-cycle clear
    loadCnt(16'h2222);
    capPin = 1'b0; step(2);
    capClr = 1'b1; step(1); capClr = 1'b0;
    chk("R7 capture set beats clear", capFlag, 1);
    capPin = 1'b1; step(3);

    // R8 interrupt gating
    irqEn = 1'b0; step(1);
    chk("R8 irq masked", irq, 0);
    irqEn = 1'b1; step(1);
    chk("R8 irq unmasked", irq, 1);

    // R9 reset mid-run
    runEn = 1'b1; tick = 1'b1;
    rst = 1'b1; step(1); rst = 1'b0; runEn = 1'b0; tick = 1'b0;
    chk("R9 count after reset", count, 0);
    chk("R9 capValue after reset", capValue, 0);
    chk("R9 flags after reset", {wrapFlag, capFlag, irq}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule